// File: doc/BRIEF.md
# Two-Thread Partitioned Instruction Queue

This block sits between two pipeline stages and holds micro-operations for two hardware threads. Each write carries a thread ID. A single read port serves the two threads, alternating between them whenever both have work. Entries of one thread leave in the order they arrived. The two threads have no ordering relative to each other.

The occupancy of each thread is capped, so neither thread can crowd the other out. While both threads run, each may hold at most half of the entries. When one thread is halted, the other may use the whole queue. A configuration input chooses between two placement schemes:

- **Fixed halves:** thread 0 keeps to the lower half of the slots and thread 1 to the upper half.
- **Shared pool:** either thread may take any free slot, within its quota.

A halt or resume request waits until the requesting thread has drained, so no entry is ever stranded. Per-thread full, empty, occupancy and halted outputs let the neighbouring stages steer their traffic.

Top module: `smt_split_queue`

## Requirements
- R1: While neither thread is halted, an accepted write never raises a thread's occupancy above DEPTH/2. `thr_full` of that thread is high whenever its occupancy is DEPTH/2 or more.
- R2: With `part_dyn`=0 and both threads running, thread 0 may only use slots 0 to DEPTH/2-1 and thread 1 only slots DEPTH/2 to DEPTH-1. A write takes the lowest-numbered free slot of the allowed range. A thread reports full when no slot in its range is free, even if it is below its quota.
- R3: With `part_dyn`=1, or whenever the other thread is halted, a thread may take the lowest-numbered free slot anywhere in the queue. The two occupancies never sum to more than DEPTH.
- R4: While a thread is halted, its quota is zero and `thr_full` is high for it, so its writes are dropped. The other thread's quota rises to DEPTH.
- R5: A change of `halt_req[t]` takes effect on a clock edge only when thread t holds no entries and no write of thread t is accepted at that edge. A halt is refused while the other thread is halted. When both threads ask to halt in the same cycle, thread 0 is halted. `thr_halted` shows the current state.
- R6: A write to a thread whose `thr_full` is high is dropped and leaves every occupancy and stored entry unchanged.
- R7: Data of one thread leaves in the same order it was written.
- R8: A thread is eligible when it has an entry and its `deq_ready` bit is high. `deq_valid` is high exactly when some thread is eligible, and the entry shown leaves in that cycle. When both threads are eligible, the thread not served last time is chosen.
- R9: A thread that is full or whose `deq_ready` is low does not stop the other thread from writing or reading.
- R10: `thr_count0`/`thr_count1` give the current occupancies, and `thr_empty[t]` is high exactly when thread t holds nothing.
- R11: A synchronous active-low reset empties the queue and leaves both threads running. Thread 0 is served first when both threads become eligible after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| part_dyn | input | 1 | 0: fixed halves, 1: shared pool |
| halt_req | input | 2 | Per-thread halt request (bit t for thread t) |
| enq_valid | input | 1 | Write attempt this cycle |
| enq_tid | input | 1 | Thread of the write |
| enq_data | input | DATA_W | Micro-operation payload |
| deq_ready | input | 2 | Per-thread downstream ready |
| deq_valid | output | 1 | An entry leaves this cycle |
| deq_tid | output | 1 | Thread of the leaving entry |
| deq_data | output | DATA_W | Payload of the leaving entry |
| thr_full | output | 2 | Per-thread full (writes dropped) |
| thr_empty | output | 2 | Per-thread empty |
| thr_count0 | output | clog2(DEPTH+1) | Occupancy of thread 0 |
| thr_count1 | output | clog2(DEPTH+1) | Occupancy of thread 1 |
| thr_halted | output | 2 | Per-thread halted state |

## Verification
The assertions assume that reset is held for at least one clock edge before traffic starts. They also assume that `part_dyn` is only changed while the queue is idle, because the checks on fixed-half placement reason about slots taken under one scheme. The bench respects both: it resets before each sweep and sets `part_dyn` only between sweeps. Inside a sweep it runs every pair of consecutive combinations of write, thread, ready and halt inputs in a four-entry queue. This lets halt requests arrive at arbitrary occupancies without ever breaking what the checker relies on.

// File: rtl/smtq_pkg.sv
// Shared types for the two-thread partitioned queue.
// Assumes exactly two threads; thread IDs are one bit wide.
package smtq_pkg;

    // Placement scheme selected by the configuration input
    typedef enum logic {
        PART_FIXED  = 1'b0,
        PART_SHARED = 1'b1
    } part_mode_e;

    // Result of the read-side arbitration
    typedef struct packed {
        logic valid;
        logic tid;
    } pick_t;

endpackage

// File: rtl/smtq_slot_pick.sv
// Finds the lowest-numbered set bit of a free-slot mask.
// Assumes the mask already excludes slots the thread may not use.
module smtq_slot_pick #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0] free_mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so that the lowest free slot wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/smtq_order_fifo.sv
// Keeps the arrival order of one thread as a ring of slot indices.
// Assumes the caller never pushes when DEPTH indices are held
// and never pops when empty.
module smtq_order_fifo #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] count
);

    logic [IDX_W-1:0] ring [DEPTH];
    logic [IDX_W-1:0] rd_ptr;
    logic [IDX_W-1:0] wr_ptr;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the slot index of each accepted write
    always_ff @(posedge clk) begin
        if (push) ring[wr_ptr] <= push_idx;
    end

    // Advance the pointers and track the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_idx = ring[rd_ptr];

endmodule

// File: rtl/smtq_deq_arb.sv
// Chooses which thread reads this cycle; alternates when both are eligible.
// Assumes eligibility already includes downstream ready and non-empty.
module smtq_deq_arb
    import smtq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    output pick_t      pick
);

    logic last_tid;

    // Select a thread, favouring the one not served last
    always_comb begin
        pick.valid = |elig;
        if (&elig) pick.tid = ~last_tid;
        else       pick.tid = elig[1];
    end

    // Remember the last served thread; reset makes thread 0 go first
    always_ff @(posedge clk) begin
        if (!rst_n)          last_tid <= 1'b1;
        else if (pick.valid) last_tid <= pick.tid;
    end

endmodule

// File: rtl/smt_split_queue.sv
// Two-thread queue with per-thread occupancy caps and a choice of fixed
// or shared slot placement. A halted thread hands its share to the other.
// Assumes DEPTH is even and at least 2, and that part_dyn changes only
// while the queue is idle.
module smt_split_queue
    import smtq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         part_dyn,
    input  logic [1:0]                   halt_req,
    input  logic                         enq_valid,
    input  logic                         enq_tid,
    input  logic [DATA_W-1:0]            enq_data,
    input  logic [1:0]                   deq_ready,
    output logic                         deq_valid,
    output logic                         deq_tid,
    output logic [DATA_W-1:0]            deq_data,
    output logic [1:0]                   thr_full,
    output logic [1:0]                   thr_empty,
    output logic [$clog2(DEPTH+1)-1:0]   thr_count0,
    output logic [$clog2(DEPTH+1)-1:0]   thr_count1,
    output logic [1:0]                   thr_halted
);

    localparam int HALF  = DEPTH / 2;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic logic [DEPTH-1:0] low_half_mask();
        logic [DEPTH-1:0] m;
        m = '0;
        for (int i = 0; i < HALF; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [DEPTH-1:0] LOW_MASK = low_half_mask();

    logic [DATA_W-1:0]        store [DEPTH];
    logic [DEPTH-1:0]         busy;
    logic [DEPTH-1:0]         set_vec;
    logic [DEPTH-1:0]         clr_vec;
    logic [1:0]               halted;
    logic [1:0]               halted_nx;
    logic [1:0][CNT_W-1:0]    cnt;
    logic [1:0][CNT_W-1:0]    quota;
    logic [1:0][DEPTH-1:0]    allow;
    logic [1:0][IDX_W-1:0]    head_slot;
    logic [1:0][IDX_W-1:0]    new_slot;
    logic [1:0]               slot_ok;
    logic [1:0]               cap_hit;
    logic [1:0]               push;
    logic [1:0]               pop;
    logic [1:0]               elig;
    part_mode_e               mode;
    pick_t                    pick;

    assign mode = part_mode_e'(part_dyn);

    // Per-thread quota, slot range, full/empty and order tracking
    for (genvar t = 0; t < 2; t++) begin : g_thr
        localparam logic [DEPTH-1:0] OWN = (t == 0) ? LOW_MASK : ~LOW_MASK;

        assign quota[t]   = halted[1-t] ? CNT_W'(DEPTH) : CNT_W'(HALF);
        assign allow[t]   = (mode == PART_SHARED || halted[1-t]) ? ~busy
                                                                 : (~busy & OWN);
        assign cap_hit[t] = (cnt[t] >= quota[t]);
        assign thr_full[t]  = halted[t] | cap_hit[t] | ~slot_ok[t];
        assign thr_empty[t] = (cnt[t] == '0);
        assign push[t] = enq_valid && (enq_tid == 1'(t)) && !thr_full[t];
        assign elig[t] = !thr_empty[t] && deq_ready[t];
        assign pop[t]  = pick.valid && (pick.tid == 1'(t));

        smtq_slot_pick #(
            .DEPTH (DEPTH),
            .IDX_W (IDX_W)
        ) u_pick (
            .free_mask (allow[t]),
            .found     (slot_ok[t]),
            .idx       (new_slot[t])
        );

        smtq_order_fifo #(
            .DEPTH (DEPTH),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W)
        ) u_order (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[t]),
            .push_idx (new_slot[t]),
            .pop      (pop[t]),
            .head_idx (head_slot[t]),
            .count    (cnt[t])
        );
    end

    smtq_deq_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .pick  (pick)
    );

    // One-hot masks of the slot taken and the slot released this cycle
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (|push)      set_vec[new_slot[enq_tid]]   = 1'b1;
        if (pick.valid) clr_vec[head_slot[pick.tid]] = 1'b1;
    end

    // Write the payload into the chosen slot
    always_ff @(posedge clk) begin
        if (|push) store[new_slot[enq_tid]] <= enq_data;
    end

    // Track which slots hold live entries
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy & ~clr_vec) | set_vec;
    end

    // Halt changes wait for an empty thread; thread 0 wins a tie
    always_comb begin
        halted_nx = halted;
        if (cnt[0] == '0 && !push[0])
            halted_nx[0] = halt_req[0] && !halted[1];
        if (cnt[1] == '0 && !push[1])
            halted_nx[1] = halt_req[1] && !halted_nx[0];
    end

    // Register the mode of each thread
    always_ff @(posedge clk) begin
        if (!rst_n) halted <= 2'b00;
        else        halted <= halted_nx;
    end

    assign deq_valid  = pick.valid;
    assign deq_tid    = pick.tid;
    assign deq_data   = store[head_slot[pick.tid]];
    assign thr_count0 = cnt[0];
    assign thr_count1 = cnt[1];
    assign thr_halted = halted;

endmodule

// File: rtl/smtq_checker.sv
// Properties of the partitioned queue, observed at its ports.
// Assumes reset is applied before traffic and part_dyn changes only when idle.
module smtq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             enq_tid,
    input logic [1:0]       deq_ready,
    input logic             deq_valid,
    input logic             deq_tid,
    input logic [1:0]       thr_full,
    input logic [1:0]       thr_empty,
    input logic [CNT_W-1:0] thr_count0,
    input logic [CNT_W-1:0] thr_count1,
    input logic [1:0]       thr_halted
);

    localparam int HALF = DEPTH / 2;

    logic armed;

    // Marks cycles whose previous edge was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_CAP_T0: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_tid && !thr_halted[1] && thr_count0 >= CNT_W'(HALF))
        |=> thr_count0 <= $past(thr_count0)); // R1
    AST_CAP_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_tid && !thr_halted[0] && thr_count1 >= CNT_W'(HALF))
        |=> thr_count1 <= $past(thr_count1)); // R1
    AST_FULL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_halted[1] && thr_count0 >= CNT_W'(HALF)) |-> thr_full[0]); // R1
    AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, thr_count0} + {1'b0, thr_count1}) <= (CNT_W+1)'(DEPTH)); // R3
    AST_HALTED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        thr_halted[0] |-> thr_full[0]); // R4
    AST_HALT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_halted[1]) |-> thr_empty[1]); // R5
    AST_ONE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        thr_halted != 2'b11); // R5
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_tid && thr_full[0]) |=> thr_count0 <= $past(thr_count0)); // R6
    AST_READ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> (deq_ready[deq_tid] && !thr_empty[deq_tid])); // R8
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(deq_valid) && deq_ready == 2'b11 && thr_empty == 2'b00)
        |-> deq_tid != $past(deq_tid)); // R8
    AST_NO_BLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_ready[1] && !thr_empty[1]) |-> deq_valid); // R9

endmodule

bind smt_split_queue smtq_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_tid    (enq_tid),
    .deq_ready  (deq_ready),
    .deq_valid  (deq_valid),
    .deq_tid    (deq_tid),
    .thr_full   (thr_full),
    .thr_empty  (thr_empty),
    .thr_count0 (thr_count0),
    .thr_count1 (thr_count1),
    .thr_halted (thr_halted)
);

// File: tb/sim_smt_split_queue.sv
`timescale 1ns/1ps
// Sweeps a four-entry queue; expected values come from an arithmetic model
// of the requirements kept in the bench.
module sim_smt_split_queue;

    localparam int D  = 4;
    localparam int H  = D / 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          part_dyn = 1'b0;
    logic [1:0]    halt_req = 2'b00;
    logic          enq_valid = 1'b0;
    logic          enq_tid = 1'b0;
    logic [DW-1:0] enq_data = '0;
    logic [1:0]    deq_ready = 2'b00;
    logic          deq_valid;
    logic          deq_tid;
    logic [DW-1:0] deq_data;
    logic [1:0]    thr_full;
    logic [1:0]    thr_empty;
    logic [2:0]    thr_count0;
    logic [2:0]    thr_count1;
    logic [1:0]    thr_halted;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model state
    int        mc [2];
    bit        mh [2];
    bit        mlast;
    bit        mbusy [D];
    int        sq0 [$];
    int        sq1 [$];
    int        dq0 [$];
    int        dq1 [$];
    bit        efull [2];
    bit        evalid;
    bit        etid;
    int        seq = 1;

    smt_split_queue #(.DEPTH(D), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .part_dyn(part_dyn), .halt_req(halt_req),
        .enq_valid(enq_valid), .enq_tid(enq_tid), .enq_data(enq_data),
        .deq_ready(deq_ready), .deq_valid(deq_valid), .deq_tid(deq_tid),
        .deq_data(deq_data), .thr_full(thr_full), .thr_empty(thr_empty),
        .thr_count0(thr_count0), .thr_count1(thr_count1), .thr_halted(thr_halted)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit in_range(input int t, input int i);
        if (part_dyn || mh[1-t]) return 1'b1;
        return (i >= H) == (t == 1);
    endfunction

    task automatic model_eval();
        bit elig [2];
        for (int t = 0; t < 2; t++) begin
            int q;
            bit avail;
            q = mh[1-t] ? D : H;
            avail = 1'b0;
            for (int i = 0; i < D; i++)
                if (!mbusy[i] && in_range(t, i)) avail = 1'b1;
            efull[t] = mh[t] || (mc[t] >= q) || !avail;
            elig[t]  = (mc[t] > 0) && deq_ready[t];
        end
        evalid = elig[0] || elig[1];
        etid   = (elig[0] && elig[1]) ? !mlast : elig[1];
    endtask

    task automatic model_update();
        bit acc;
        bit nh0;
        bit nh1;
        int t;
        t   = int'(enq_tid);
        acc = enq_valid && !efull[t];
        nh0 = (mc[0] == 0 && !(acc && t == 0)) ? (halt_req[0] && !mh[1]) : mh[0];
        nh1 = (mc[1] == 0 && !(acc && t == 1)) ? (halt_req[1] && !nh0) : mh[1];
        if (acc) begin
            int s;
            s = -1;
            for (int i = D - 1; i >= 0; i--)
                if (!mbusy[i] && in_range(t, i)) s = i;
            mbusy[s] = 1'b1;
            if (t == 0) begin sq0.push_back(s); dq0.push_back(int'(enq_data)); end
            else        begin sq1.push_back(s); dq1.push_back(int'(enq_data)); end
            mc[t]++;
        end
        if (evalid) begin
            int s;
            if (etid == 1'b0) begin s = sq0.pop_front(); void'(dq0.pop_front()); end
            else              begin s = sq1.pop_front(); void'(dq1.pop_front()); end
            mbusy[s] = 1'b0;
            mc[int'(etid)]--;
            mlast = etid;
        end
        mh[0] = nh0;
        mh[1] = nh1;
    endtask

    task automatic model_clear();
        mc[0] = 0; mc[1] = 0; mh[0] = 0; mh[1] = 0; mlast = 1'b1;
        for (int i = 0; i < D; i++) mbusy[i] = 1'b0;
        sq0.delete(); sq1.delete(); dq0.delete(); dq1.delete();
    endtask

    // One clock: drive, compare away from the edge, then advance the model
    task automatic cyc(input bit e, input bit t, input bit [1:0] r, input bit [1:0] h,
                       input string tag);
        enq_valid = e;
        enq_tid   = t;
        enq_data  = DW'(seq);
        seq++;
        deq_ready = r;
        halt_req  = h;
        @(negedge clk);
        model_eval();
        chk("R10", "count0", int'(thr_count0), mc[0]);
        chk("R10", "count1", int'(thr_count1), mc[1]);
        chk("R10", "empty",  int'(thr_empty), {30'd0, mc[1] == 0, mc[0] == 0});
        chk(tag,   "full",   int'(thr_full), {30'd0, efull[1], efull[0]});
        chk("R5",  "halted", int'(thr_halted), {30'd0, mh[1], mh[0]});
        chk("R8",  "deq_valid", int'(deq_valid), int'(evalid));
        if (evalid) begin
            chk("R8", "deq_tid", int'(deq_tid), int'(etid));
            chk("R7", "deq_data", int'(deq_data), (etid == 1'b0) ? dq0[0] : dq1[0]);
        end
        @(posedge clk);
        model_update();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        enq_valid = 1'b0;
        halt_req = 2'b00;
        deq_ready = 2'b00;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        #1;
        for (int p = 0; p < 2; p++) begin
            part_dyn = p[0];
            do_reset();
            // R11: state right after reset
            cyc(0, 0, 2'b00, 2'b00, "R11");
            // R1, R6: fill thread 0 to its cap, then a dropped write
            cyc(1, 0, 2'b00, 2'b00, "R1");
            cyc(1, 0, 2'b00, 2'b00, "R1");
            cyc(1, 0, 2'b00, 2'b00, "R6");
            cyc(1, 1, 2'b00, 2'b00, "R1");
            cyc(1, 1, 2'b00, 2'b00, "R1");
            cyc(1, 1, 2'b00, 2'b00, "R6");
            // R8, R11: drain both; thread 0 first, then alternation
            for (int k = 0; k < 5; k++) cyc(0, 0, 2'b11, 2'b00, "R8");
            // R9: thread 0 blocked downstream and full, thread 1 still flows
            cyc(1, 0, 2'b00, 2'b00, "R9");
            cyc(1, 0, 2'b00, 2'b00, "R9");
            for (int k = 0; k < 6; k++) cyc(1, 1, 2'b10, 2'b00, "R9");
            cyc(0, 0, 2'b11, 2'b00, "R9");
            cyc(0, 0, 2'b11, 2'b00, "R9");
            cyc(0, 0, 2'b11, 2'b00, "R9");
            // R5: halt deferred while thread 0 holds an entry
            cyc(0, 0, 2'b00, 2'b01, "R5");
            cyc(0, 0, 2'b01, 2'b01, "R5");
            cyc(0, 0, 2'b00, 2'b11, "R5");
            // R4: thread 1 uses the whole queue, thread 0 writes dropped
            for (int k = 0; k < 5; k++) cyc(1, 1, 2'b00, 2'b11, "R4");
            cyc(1, 0, 2'b00, 2'b01, "R4");
            // resume thread 0 while thread 1 holds everything
            cyc(0, 0, 2'b00, 2'b00, "R4");
            cyc(1, 0, 2'b00, 2'b00, "R1");
            for (int k = 0; k < 5; k++) cyc(0, 0, 2'b11, 2'b00, "R7");
            // R2 vs R3: thread 1 keeps the lower slots after its solo run
            cyc(1, 1, 2'b00, 2'b00, "R3");
            cyc(1, 1, 2'b00, 2'b00, "R3");
            cyc(0, 0, 2'b00, 2'b01, "R5");
            cyc(1, 1, 2'b00, 2'b01, "R3");
            cyc(1, 1, 2'b00, 2'b01, "R3");
            cyc(0, 0, 2'b00, 2'b00, "R5");
            cyc(0, 0, 2'b10, 2'b00, "R3");
            cyc(0, 0, 2'b10, 2'b00, p ? "R3" : "R2");
            cyc(1, 0, 2'b00, 2'b00, p ? "R3" : "R2");
            cyc(0, 0, 2'b00, 2'b00, p ? "R3" : "R2");
            // R11: reset in the middle of traffic
            do_reset();
            cyc(0, 0, 2'b00, 2'b00, "R11");
            // Sweep every pair of consecutive input combinations
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    cyc(a[0], a[1], a[3:2], a[5:4], p ? "R3" : "R2");
                    cyc(b[0], b[1], b[3:2], b[5:4], "R6");
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule